// File: doc/BRIEF.md
# Signed Multiply-Divide Unit

This block multiplies or divides two signed two's-complement integers at one of three operand sizes: 8, 16 or 32 bits. The caller presents an opcode, a size code and two operands, and pulses `start` while the unit is idle. The unit works on operand magnitudes: a shift-add loop for products and a restoring loop for quotients, one bit per cycle. A final cycle then applies the sign and derives the condition flags. The sized result is returned sign-extended to 32 bits, with `done` pulsing for one cycle.

Division truncates toward zero. Overflow is reported in V whenever the signed outcome cannot be held in the selected size. A zero divisor is caught in the accepting cycle: it raises V and a one-cycle exception pulse and leaves the result register untouched. No iteration is run in that case.

Top module: `smd_unit`

## Requirements
- R1: With `op_div`=0, `result` holds the low n bits of the signed product of the sized operands, sign-extended to 32 bits (n = 8, 16 or 32).
- R2: A product outside the signed range of n bits sets `flag_v`; a product inside it clears `flag_v`.
- R3: With `op_div`=1, the quotient truncates toward zero, so 7/2=3, 7/-2=-3, -7/2=-3 and -7/-2=3.
- R4: Dividing the most negative n-bit value by -1 sets `flag_v`, and `result` equals the sized dividend.
- R5: A divisor whose low n bits are all zero makes `done` and `div_zero_exc` high for one cycle right after the accepting clock edge. In that case `flag_v`=1, `flag_n`=0, `flag_z`=0, `result` keeps its previous value and `busy` never rises.
- R6: `flag_c` is 0 after every operation.
- R7: After a completed multiply or divide, `flag_n` equals bit n-1 of the sized result and `flag_z` is 1 exactly when the sized result is zero.
- R8: Counting clock edges after the edge that accepts `start`, a non-faulting operation has n iteration edges and then one fixup edge. `done` is high for the one cycle after the fixup edge. `busy` is high from the accepting edge until that fixup edge, and it is low while `done` is high.
- R9: `start` is ignored while `busy` is high: it neither restarts the operation nor produces an extra `done`.
- R10: `size` codes are 0 = byte, 1 = word, 2 or 3 = longword. Operand bits above the selected size are ignored.
- R11: After synchronous reset, `result`, all flags, `div_zero_exc`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| size | input | 2 | Operand size code |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| result | output | 32 | Sized result, sign-extended |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Signed overflow or zero divisor |
| flag_c | output | 1 | Carry, always clear |
| div_zero_exc | output | 1 | One-cycle zero-divisor exception |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A faulting divide must show its `done` in the cycle right after the accepting edge. Every other operation must show it n+1 edges later still, that is 9, 17 or 33 edges past the accepting one. The driver stamps each queued expectation with the cycle count at which `start` was raised. The monitor samples on the falling edge and compares the elapsed cycles against that per-size figure before it compares the result and flags. Any `done` that arrives with an empty queue, including one caused by an intruding `start` during `busy`, is reported as a failure.

// File: rtl/smd_pkg.sv
package smd_pkg;

    localparam int SMD_W     = 32;
    localparam int SMD_CNT_W = $clog2(SMD_W + 1);

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } smd_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } smd_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } smd_state_e;

    typedef struct packed {
        smd_op_e   op;
        smd_size_e sz;
        logic      neg;
    } smd_job_t;

    function automatic int unsigned size_bits(smd_size_e s);
        case (s)
            SZ_BYTE: return 8;
            SZ_WORD: return 16;
            default: return SMD_W;
        endcase
    endfunction

    function automatic logic [SMD_W-1:0] sext_sized(logic [SMD_W-1:0] v, smd_size_e s);
        case (s)
            SZ_BYTE: return {{(SMD_W-8){v[7]}}, v[7:0]};
            SZ_WORD: return {{(SMD_W-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [SMD_W-1:0] magnitude(logic [SMD_W-1:0] v);
        return v[SMD_W-1] ? (~v + 1'b1) : v;
    endfunction

    function automatic logic fits_sized(logic [2*SMD_W-1:0] v, smd_size_e s);
        logic [2*SMD_W-1:0] t;
        t = $signed(v) >>> (size_bits(s) - 1);
        return (t == '0) || (t == '1);
    endfunction

endpackage

// File: rtl/smd_ctrl.sv
module smd_ctrl
    import smd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      is_div,
    input  logic      div_zero,
    input  smd_size_e size,
    output logic      load,
    output logic      dz_take,
    output logic      step,
    output logic      fix,
    output logic      busy
);

    smd_state_e           state;
    logic [SMD_CNT_W-1:0] cnt;
    logic                 idle;

    assign idle    = (state == ST_IDLE);
    assign dz_take = start && idle && is_div && div_zero;
    assign load    = start && idle && !(is_div && div_zero);
    assign step    = (state == ST_ITER);
    assign fix     = (state == ST_FIX);
    assign busy    = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        state <= ST_ITER;
                        cnt   <= SMD_CNT_W'(size_bits(size));
                    end
                end
                ST_ITER: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == SMD_CNT_W'(1))
                        state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a start seen mid-run never reloads the iteration count
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER && cnt > SMD_CNT_W'(1)) |=> (state == ST_ITER && cnt == $past(cnt) - 1'b1));

    // R8: the fixup phase lasts exactly one cycle
    assert_fix_single_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |=> (state == ST_IDLE));

    // R8: last iteration hands over to fixup
    assert_iter_to_fix_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ITER && cnt == SMD_CNT_W'(1)) |=> (state == ST_FIX));

endmodule

// File: rtl/smd_iter.sv
module smd_iter
    import smd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  smd_size_e            size,
    input  logic [SMD_W-1:0]     a_mag,
    input  logic [SMD_W-1:0]     b_mag,
    output logic [2*SMD_W-1:0]   prod,
    output logic [SMD_W-1:0]     quot
);

    logic [2*SMD_W-1:0] acc;
    logic [2*SMD_W-1:0] mcand;
    logic [SMD_W-1:0]   mplr;
    logic [SMD_W-1:0]   rem;
    logic [SMD_W-1:0]   qsh;
    logic [SMD_W-1:0]   dvs;
    logic [SMD_W:0]     shifted;
    logic [SMD_W:0]     diff;
    logic               borrow;

    always_comb begin
        shifted = {rem, qsh[SMD_W-1]};
        diff    = shifted - {1'b0, dvs};
        borrow  = diff[SMD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            mcand <= '0;
            mplr  <= '0;
            rem   <= '0;
            qsh   <= '0;
            dvs   <= '0;
        end else if (load) begin
            acc   <= '0;
            mcand <= {{SMD_W{1'b0}}, a_mag};
            mplr  <= b_mag;
            rem   <= '0;
            qsh   <= a_mag << (SMD_W - size_bits(size));
            dvs   <= b_mag;
        end else if (step) begin
            if (mplr[0])
                acc <= acc + mcand;
            mcand <= mcand << 1;
            mplr  <= mplr >> 1;
            rem   <= borrow ? shifted[SMD_W-1:0] : diff[SMD_W-1:0];
            qsh   <= {qsh[SMD_W-2:0], ~borrow};
        end
    end

    assign prod = acc;
    assign quot = qsh;

    // R3: restoring divider keeps the partial remainder below the divisor
    assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (step && dvs != '0) |-> (rem < dvs));

endmodule

// File: rtl/smd_fixup.sv
module smd_fixup
    import smd_pkg::*;
(
    input  smd_job_t             job,
    input  logic [2*SMD_W-1:0]   prod,
    input  logic [SMD_W-1:0]     quot,
    output logic [SMD_W-1:0]     res,
    output logic                 ovf,
    output logic                 sign,
    output logic                 zero
);

    logic [2*SMD_W-1:0] mag2;
    logic [2*SMD_W-1:0] sval;

    always_comb begin
        mag2 = (job.op == OP_MUL) ? prod : {{SMD_W{1'b0}}, quot};
        sval = job.neg ? (~mag2 + 1'b1) : mag2;
        ovf  = !fits_sized(sval, job.sz);
        res  = sext_sized(sval[SMD_W-1:0], job.sz);
        sign = res[SMD_W-1];
        zero = (res == '0);
    end

endmodule

// File: rtl/smd_unit.sv
module smd_unit
    import smd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_div,
    input  logic [1:0]        size,
    input  logic [SMD_W-1:0]  opa,
    input  logic [SMD_W-1:0]  opb,
    output logic [SMD_W-1:0]  result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              div_zero_exc,
    output logic              busy,
    output logic              done
);

    smd_size_e          sz_in;
    logic [SMD_W-1:0]   a_s, b_s, a_mag, b_mag;
    logic               dz_in;
    logic               load, dz_take, step, fix;
    smd_job_t           job_q;
    logic [2*SMD_W-1:0] prod;
    logic [SMD_W-1:0]   quot;
    logic [SMD_W-1:0]   fx_res;
    logic               fx_ovf, fx_sign, fx_zero;

    always_comb begin
        sz_in = smd_size_e'(size);
        a_s   = sext_sized(opa, sz_in);
        b_s   = sext_sized(opb, sz_in);
        a_mag = magnitude(a_s);
        b_mag = magnitude(b_s);
        dz_in = (b_s == '0);
    end

    smd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_div   (op_div),
        .div_zero (dz_in),
        .size     (sz_in),
        .load     (load),
        .dz_take  (dz_take),
        .step     (step),
        .fix      (fix),
        .busy     (busy)
    );

    smd_iter u_iter (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .step  (step),
        .size  (sz_in),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (prod),
        .quot  (quot)
    );

    smd_fixup u_fixup (
        .job  (job_q),
        .prod (prod),
        .quot (quot),
        .res  (fx_res),
        .ovf  (fx_ovf),
        .sign (fx_sign),
        .zero (fx_zero)
    );

    always_ff @(posedge clk) begin
        if (rst)
            job_q <= '{op: OP_MUL, sz: SZ_BYTE, neg: 1'b0};
        else if (load)
            job_q <= '{op: smd_op_e'(op_div), sz: sz_in, neg: a_s[SMD_W-1] ^ b_s[SMD_W-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            flag_n       <= 1'b0;
            flag_z       <= 1'b0;
            flag_v       <= 1'b0;
            div_zero_exc <= 1'b0;
            done         <= 1'b0;
        end else begin
            done         <= 1'b0;
            div_zero_exc <= 1'b0;
            if (fix) begin
                result <= fx_res;
                flag_n <= fx_sign;
                flag_z <= fx_zero;
                flag_v <= fx_ovf;
                done   <= 1'b1;
            end else if (dz_take) begin
                flag_n       <= 1'b0;
                flag_z       <= 1'b0;
                flag_v       <= 1'b1;
                div_zero_exc <= 1'b1;
                done         <= 1'b1;
            end
        end
    end

    assign flag_c = 1'b0;

    // R5: exception pulse comes with done and V, never mid-run
    assert_dz_flags_R5: assert property (@(posedge clk) disable iff (rst)
        div_zero_exc |-> (done && flag_v && !busy));

    // R5: zero divisor answered on the next cycle without writing the result
    assert_dz_next_R5: assert property (@(posedge clk) disable iff (rst)
        dz_take |=> (done && div_zero_exc && $stable(result)));

    // R8: done and busy never overlap
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: busy only ends by completing
    assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: N and Z agree with the delivered result
    assert_flags_track_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero_exc) |-> (flag_z == (result == '0) && flag_n == result[SMD_W-1]));

endmodule

// File: tb/smd_unit_tb_top.sv
`timescale 1ns/1ps
module smd_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, div_zero_exc, busy, done;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    logic [31:0] last_res = '0;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        n, z, v, dz;
        longint      t0;
        longint      lat;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    smd_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div), .size(size),
        .opa(opa), .opb(opb), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .div_zero_exc(div_zero_exc),
        .busy(busy), .done(done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(logic [31:0] v, logic [1:0] s);
        case (s)
            2'd0:    return {{24{v[7]}}, v[7:0]};
            2'd1:    return {{16{v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic int nbits(logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    task automatic issue(string tag, logic dv, logic [1:0] s, logic [31:0] a, logic [31:0] b);
        exp_t e;
        longint x, y, p, lim;
        logic [63:0] pv;
        int n;
        @(negedge clk);
        while (busy) @(negedge clk);
        n = nbits(s);
        x = longint'($signed(sx(a, s)));
        y = longint'($signed(sx(b, s)));
        e.tag = tag;
        e.t0  = cyc;
        if (dv && y == 0) begin
            e.res = last_res; e.n = 1'b0; e.z = 1'b0; e.v = 1'b1; e.dz = 1'b1; e.lat = 1;
        end else begin
            p   = dv ? (x / y) : (x * y);
            lim = longint'(1) << (n - 1);
            pv  = p;
            e.res = sx(pv[31:0], s);
            e.v   = (p < -lim) || (p > lim - 1);
            e.n   = e.res[31];
            e.z   = (e.res == '0);
            e.dz  = 1'b0;
            e.lat = n + 2;
            last_res = e.res;
        end
        q.push_back(e);
        op_div = dv; size = s; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected done: actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({"R1/R3/R4 ", e.tag}, "result", result, e.res);
                chk({"R2/R4/R5 ", e.tag}, "V", {31'd0, flag_v}, {31'd0, e.v});
                chk({"R7 ", e.tag}, "N", {31'd0, flag_n}, {31'd0, e.n});
                chk({"R7 ", e.tag}, "Z", {31'd0, flag_z}, {31'd0, e.z});
                chk({"R6 ", e.tag}, "C", {31'd0, flag_c}, 32'd0);
                chk({"R5 ", e.tag}, "exc", {31'd0, div_zero_exc}, {31'd0, e.dz});
                chk({"R8 ", e.tag}, "latency", 32'(cyc - e.t0), 32'(e.lat));
            end
        end else if (!rst && div_zero_exc) begin
            checks++; errors++;
            $display("FAIL R5 exception without done: actual=1 expected=0");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "result", result, 32'd0);
        chk("R11", "flags", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
        chk("R11", "busy/done/exc", {29'd0, busy, done, div_zero_exc}, 32'd0);

        // R1 R2 multiplies
        issue("R1 byte 5*-3", 1'b0, 2'd0, 32'd5, 32'hFFFF_FFFD);
        issue("R2 byte 16*8", 1'b0, 2'd0, 32'd16, 32'd8);
        issue("R2 byte -16*8", 1'b0, 2'd0, 32'hF0, 32'd8);
        issue("R2 word 300*-200", 1'b0, 2'd1, 32'd300, 32'hFF38);
        issue("R2 long 2^16*2^16", 1'b0, 2'd2, 32'h0001_0000, 32'h0001_0000);
        issue("R7 long 0*x", 1'b0, 2'd2, 32'd0, 32'h1234_5678);
        issue("R1 long -7*6", 1'b0, 2'd2, 32'hFFFF_FFF9, 32'd6);
        issue("R10 byte upper bits ignored", 1'b0, 2'd0, 32'hABCD_0003, 32'h1234_0004);
        issue("R10 size 3 is long", 1'b0, 2'd3, 32'h0000_1000, 32'hFFFF_F000);

        // R3 truncation toward zero
        issue("R3 7/2", 1'b1, 2'd2, 32'd7, 32'd2);
        issue("R3 7/-2", 1'b1, 2'd2, 32'd7, 32'hFFFF_FFFE);
        issue("R3 -7/2", 1'b1, 2'd2, 32'hFFFF_FFF9, 32'd2);
        issue("R3 -7/-2", 1'b1, 2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
        issue("R3 word -30000/7", 1'b1, 2'd1, 32'h8AD0, 32'd7);
        issue("R3 byte 100/100", 1'b1, 2'd0, 32'd100, 32'd100);

        // R4 most negative by -1
        issue("R4 byte", 1'b1, 2'd0, 32'h80, 32'hFF);
        issue("R4 word", 1'b1, 2'd1, 32'h8000, 32'hFFFF);
        issue("R4 long", 1'b1, 2'd2, 32'h8000_0000, 32'hFFFF_FFFF);

        // R5 zero divisor, including a sized-zero divisor (R10)
        issue("R3 long 1000/-3", 1'b1, 2'd2, 32'd1000, 32'hFFFF_FFFD);
        issue("R5 long x/0", 1'b1, 2'd2, 32'd55, 32'd0);
        issue("R10 byte x/0x100", 1'b1, 2'd0, 32'd9, 32'h100);
        issue("R5 back-to-back after fault", 1'b0, 2'd1, 32'd12, 32'd12);

        // R9 start while busy
        issue("R9 long 1234*-5", 1'b0, 2'd2, 32'd1234, 32'hFFFF_FFFB);
        repeat (3) @(negedge clk);
        op_div = 1'b1; size = 2'd2; opa = 32'd9; opb = 32'd0; start = 1'b1;
        @(negedge clk);
        op_div = 1'b0; opa = 32'd3; opb = 32'd3;
        @(negedge clk);
        start = 1'b0;
        issue("R9 follow-up 6*7", 1'b0, 2'd0, 32'd6, 32'd7);

        wait (q.size() == 0 && !busy);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule